// File: doc/BRIEF.md
# Shared Timer Clock Prescaler with Per-Channel Source Select

This block produces one count-enable pulse stream for each of several timer channels, two by default. All pulses are synchronous to the system clock. A single 10-bit prescaler counter runs all the time and is shared by every channel. From this counter the block derives four tap pulses, one each for divide-by-8, divide-by-64, divide-by-256 and divide-by-1024. Each channel has its own 3-bit select code. The code chooses one of these sources for the channel:

- no pulses at all;
- a pulse on every system clock cycle;
- one of the four taps;
- an external edge pulse that arrives already synchronized, either the falling-edge pulse or the rising-edge pulse.

The prescaler counter ignores the select codes. A channel that changes to a tap therefore does not know the tap's phase. A synchronous clear input resets the shared counter, which lets software line the timers up with a known instant.

Each channel is a small state machine. Its states are CH_STOP, CH_DIRECT, CH_DIV8, CH_DIV64, CH_DIV256, CH_DIV1024, CH_EXT_FALL and CH_EXT_RISE, and the state value equals the select code. Reset puts every channel in CH_STOP. On every clock edge each channel moves to the state named by its current select code, and any state can move to any other. The channel's output is then chosen combinationally from its state.

Top module: `tmr_clk_prescaler`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every count_en bit is 0, whatever the select codes and external pulses are.
- R2: Select code 0 produces no pulses on that channel, even while its external pulse inputs toggle.
- R3: With select code 1, count_en is high in every cycle after the clock edge that samples the code. A new code always takes effect in the cycle after the edge that samples it.
- R4: Select codes 2, 3, 4 and 5 pick divisors 8, 64, 256 and 1024. With divisor N, count_en is a one-cycle pulse in the cycle after the k-th clock edge since the last clear or reset, for each k that is a positive multiple of N. The 10-bit counter wraps without a gap, so the divide-by-1024 pulse period is exactly 1024.
- R5: Both channels share one counter while keeping their codes independent. Every coarser tap pulse coincides with a divide-by-8 pulse.
- R6: Changing a select code never disturbs the counter. After a channel moves to a tap of divisor N, its first pulse comes between 1 and N+1 cycles after the code is applied.
- R7: presc_clear zeroes the shared counter synchronously and takes priority over counting. No tap pulse appears in the cycle after the clear edge, and the first divide-by-N pulse appears exactly N cycles after it.
- R8: Code 6 makes count_en follow ext_fall and code 7 makes it follow ext_rise, in the same cycle and with no prescaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_clear | input | 1 | Synchronous clear of the shared prescaler counter |
| sel_code | input | 3*NUM_CH | Per-channel select code; channel c uses bits [3c+2:3c] |
| ext_rise | input | NUM_CH | Synchronized rising-edge pulse for each channel |
| ext_fall | input | NUM_CH | Synchronized falling-edge pulse for each channel |
| count_en | output | NUM_CH | One-cycle count-enable pulse for each channel |

## Verification
The bench drives a clear and then counts the cycles to the first divide-by-64 and divide-by-8 pulses. A design that let counting win over the clear, or that registered the tap one stage late, would land one cycle off. It switches a channel onto the divide-by-256 tap at an arbitrary phase and checks that the first pulse falls in the 1 to N+1 window. A design that restarted the counter on a code change would both break this window and shift the other channel's pulses. It measures two consecutive divide-by-1024 pulses with no clear in between, which catches a counter that is too narrow or that stalls when it wraps. It also toggles the external pulse inputs while a channel sits at code 0 or on the opposite edge, which exposes any decode that leaks the wrong source.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;

    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 4;

    // log2 of each tap divisor, finest first
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    localparam int CNT_W = tap_log2(NUM_TAPS - 1);

    typedef enum logic [SEL_W-1:0] {
        CH_STOP     = 3'd0,
        CH_DIRECT   = 3'd1,
        CH_DIV8     = 3'd2,
        CH_DIV64    = 3'd3,
        CH_DIV256   = 3'd4,
        CH_DIV1024  = 3'd5,
        CH_EXT_FALL = 3'd6,
        CH_EXT_RISE = 3'd7
    } chan_state_e;

    function automatic chan_state_e decode_sel(input logic [SEL_W-1:0] code);
        chan_state_e s;
        case (code)
            3'd0:    s = CH_STOP;
            3'd1:    s = CH_DIRECT;
            3'd2:    s = CH_DIV8;
            3'd3:    s = CH_DIV64;
            3'd4:    s = CH_DIV256;
            3'd5:    s = CH_DIV1024;
            3'd6:    s = CH_EXT_FALL;
            default: s = CH_EXT_RISE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr_presc_counter.sv
module tmr_presc_counter
    import tmr_presc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NT = NUM_TAPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [NT-1:0] tap_tick
);

    logic [CW-1:0] cnt_q;

    // free-running count; a clear wins over the increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // each tap pulses in the cycle where its low bits have just wrapped
    for (genvar g = 0; g < NT; g++) begin : g_tap
        localparam int LW = tap_log2(g);
        logic tick_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tick_q <= 1'b0;
            end else begin
                tick_q <= !clear && (cnt_q[LW-1:0] == {LW{1'b1}});
            end
        end

        assign tap_tick[g] = tick_q;
    end

endmodule

// File: rtl/tmr_presc_chan_sel.sv
module tmr_presc_chan_sel
    import tmr_presc_pkg::*;
#(
    parameter int NT = NUM_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [NT-1:0]    tap_tick,
    input  logic             ext_rise,
    input  logic             ext_fall,
    output logic             count_en
);

    chan_state_e state_q;
    chan_state_e state_d;

    always_comb begin
        state_d = decode_sel(sel);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            CH_STOP:     count_en = 1'b0;
            CH_DIRECT:   count_en = 1'b1;
            CH_DIV8:     count_en = tap_tick[0];
            CH_DIV64:    count_en = tap_tick[1];
            CH_DIV256:   count_en = tap_tick[2];
            CH_DIV1024:  count_en = tap_tick[NT-1];
            CH_EXT_FALL: count_en = ext_fall;
            CH_EXT_RISE: count_en = ext_rise;
        endcase
    end

endmodule

// File: rtl/tmr_clk_prescaler.sv
module tmr_clk_prescaler
    import tmr_presc_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    presc_clear,
    input  logic [NUM_CH*SEL_W-1:0] sel_code,
    input  logic [NUM_CH-1:0]       ext_rise,
    input  logic [NUM_CH-1:0]       ext_fall,
    output logic [NUM_CH-1:0]       count_en
);

    localparam int NT = NUM_TAPS;

    logic [NT-1:0] tap_tick;

    tmr_presc_counter #(
        .CW (CNT_W),
        .NT (NT)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (presc_clear),
        .tap_tick (tap_tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tmr_presc_chan_sel #(
            .NT (NT)
        ) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel_code[c*SEL_W +: SEL_W]),
            .tap_tick (tap_tick),
            .ext_rise (ext_rise[c]),
            .ext_fall (ext_fall[c]),
            .count_en (count_en[c])
        );
    end

endmodule

// File: rtl/tmr_clk_prescaler_chk.sv
module tmr_clk_prescaler_chk
    import tmr_presc_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    presc_clear,
    input logic [NUM_CH*SEL_W-1:0] sel_code,
    input logic [NUM_CH-1:0]       ext_rise,
    input logic [NUM_CH-1:0]       ext_fall,
    input logic [NUM_CH-1:0]       count_en,
    input logic [NUM_TAPS-1:0]     tap_tick
);

    logic warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(presc_clear) |-> tap_tick == '0);

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tick[0] |=> !tap_tick[0]);

    for (genvar t = 1; t < NUM_TAPS; t++) begin : g_nest
        assert_tap_nesting_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tap_tick[t] |-> tap_tick[t-1]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(sel_code[c*SEL_W +: SEL_W]) == 3'd0 |-> !count_en[c]);

        assert_direct_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
            warm && $past(sel_code[c*SEL_W +: SEL_W]) == 3'd1 |-> count_en[c]);

        assert_ext_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            warm && $past(sel_code[c*SEL_W +: SEL_W]) == 3'd6 |-> count_en[c] == ext_fall[c]);

        assert_ext_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
            warm && $past(sel_code[c*SEL_W +: SEL_W]) == 3'd7 |-> count_en[c] == ext_rise[c]);

        for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
            assert_div_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
                warm && $past(sel_code[c*SEL_W +: SEL_W]) == 3'(t + 2) |-> count_en[c] == tap_tick[t]);
        end
    end

endmodule

bind tmr_clk_prescaler tmr_clk_prescaler_chk #(
    .NUM_CH (NUM_CH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .presc_clear (presc_clear),
    .sel_code    (sel_code),
    .ext_rise    (ext_rise),
    .ext_fall    (ext_fall),
    .count_en    (count_en),
    .tap_tick    (tap_tick)
);

// File: tb/tmr_clk_prescaler_tb.sv
module tmr_clk_prescaler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int NSEG       = 8;

    // segment: {code_a, code_b, clear, ext_active, length}
    localparam logic [15:0] SEG_TABLE [NSEG] = '{
        {3'd1, 3'd0, 1'b0, 1'b0, 8'd10},
        {3'd2, 3'd3, 1'b0, 1'b0, 8'd140},
        {3'd6, 3'd7, 1'b0, 1'b1, 8'd20},
        {3'd0, 3'd7, 1'b0, 1'b1, 8'd15},
        {3'd2, 3'd2, 1'b1, 1'b0, 8'd1},
        {3'd2, 3'd3, 1'b0, 1'b0, 8'd70},
        {3'd7, 3'd6, 1'b0, 1'b1, 8'd12},
        {3'd4, 3'd1, 1'b0, 1'b0, 8'd60}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             presc_clear = 1'b0;
    logic [3*NCH-1:0] sel_code = '0;
    logic [NCH-1:0]   ext_rise = '0;
    logic [NCH-1:0]   ext_fall = '0;
    logic [NCH-1:0]   count_en;

    int checks = 0;
    int errors = 0;
    int k_edges = 0;
    int gcyc = 0;
    int app_a = 0;
    int app_b = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_clk_prescaler #(.NUM_CH(NCH)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .presc_clear (presc_clear),
        .sel_code    (sel_code),
        .ext_rise    (ext_rise),
        .ext_fall    (ext_fall),
        .count_en    (count_en)
    );

    function automatic logic exp_en(input int code, input int k, input logic r, input logic f);
        case (code)
            0:       return 1'b0;
            1:       return 1'b1;
            2:       return (k > 0) && (k % 8 == 0);
            3:       return (k > 0) && (k % 64 == 0);
            4:       return (k > 0) && (k % 256 == 0);
            5:       return (k > 0) && (k % 1024 == 0);
            6:       return f;
            default: return r;
        endcase
    endfunction

    function automatic string req_of(input int code);
        case (code)
            0:          return "R2";
            1:          return "R3";
            6, 7:       return "R8";
            default:    return "R4";
        endcase
    endfunction

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b (cycle %0d)", req, act, exp, gcyc);
        end
    endtask

    task automatic chk_num(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // one cycle: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input logic [2:0] sa, input logic [2:0] sb, input logic clr, input logic ext);
        logic [1:0] r;
        logic [1:0] f;
        r[0] = ext && (gcyc % 3 == 0);
        r[1] = ext && (gcyc % 4 == 1);
        f[0] = ext && (gcyc % 5 == 2);
        f[1] = ext && (gcyc % 2 == 0);
        sel_code    = {sb, sa};
        presc_clear = clr;
        ext_rise    = r;
        ext_fall    = f;
        @(posedge clk);
        if (clr) k_edges = 0;
        else     k_edges++;
        app_a = int'(sa);
        app_b = int'(sb);
        gcyc++;
        @(negedge clk);
        chk_bit(req_of(app_a), count_en[0], exp_en(app_a, k_edges, r[0], f[0]));
        chk_bit(req_of(app_b), count_en[1], exp_en(app_b, k_edges, r[1], f[1]));
    endtask

    initial begin
        int n;
        int na;
        int nb;
        int both;
        int first;
        int second;

        // R1: reset holds outputs low despite active codes and pulses
        sel_code = {3'd7, 3'd1};
        ext_rise = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_bit("R1", count_en[0], 1'b0);
        chk_bit("R1", count_en[1], 1'b0);
        ext_rise = '0;
        rst_n = 1'b1;
        k_edges = 0;
        #1;
        chk_bit("R1", count_en[0], 1'b0);
        chk_bit("R1", count_en[1], 1'b0);

        // table walk: every cycle checked against the requirement model
        for (int s = 0; s < NSEG; s++) begin
            for (int i = 0; i < int'(SEG_TABLE[s][7:0]); i++) begin
                cyc(SEG_TABLE[s][15:13], SEG_TABLE[s][12:10], SEG_TABLE[s][9], SEG_TABLE[s][8]);
            end
        end

        // R7: clear priority, first /64 and /8 pulses exactly N cycles later
        cyc(3'd3, 3'd2, 1'b1, 1'b0);
        chk_bit("R7", count_en[0], 1'b0);
        chk_bit("R7", count_en[1], 1'b0);
        n = 0;
        first = 0;
        for (int i = 1; i <= 100 && n == 0; i++) begin
            cyc(3'd3, 3'd2, 1'b0, 1'b0);
            if (count_en[1] && first == 0) first = i;
            if (count_en[0]) n = i;
        end
        chk_num("R7", n, 64, 64);
        chk_num("R7", first, 8, 8);

        // R5: shared phase, /64 pulses coincide with /8 pulses
        cyc(3'd2, 3'd3, 1'b1, 1'b0);
        na = 0; nb = 0; both = 0;
        for (int i = 0; i < 128; i++) begin
            cyc(3'd2, 3'd3, 1'b0, 1'b0);
            if (count_en[0]) na++;
            if (count_en[1]) nb++;
            if (count_en[0] && count_en[1]) both++;
        end
        chk_num("R5", na, 16, 16);
        chk_num("R5", nb, 2, 2);
        chk_num("R5", both, 2, 2);

        // R6: switch to /256 at an arbitrary phase; counter keeps running
        for (int i = 0; i < 37; i++) cyc(3'd2, 3'd0, 1'b0, 1'b0);
        n = 0;
        for (int i = 1; i <= 300 && n == 0; i++) begin
            cyc(3'd2, 3'd4, 1'b0, 1'b0);
            if (count_en[1]) n = i;
        end
        chk_num("R6", n, 1, 257);
        chk_num("R6", (k_edges % 256 == 0) ? 1 : 0, 1, 1);

        // R4: /1024 wraps with exact period and no clear
        first = 0;
        second = 0;
        for (int i = 1; i <= 2100 && second == 0; i++) begin
            cyc(3'd5, 3'd1, 1'b0, 1'b0);
            if (count_en[0]) begin
                if (first == 0) first = i;
                else            second = i;
            end
        end
        chk_num("R4", second - first, 1024, 1024);

        // R1: reset asserted mid-run clears outputs at once
        cyc(3'd1, 3'd1, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        chk_bit("R1", count_en[0], 1'b0);
        chk_bit("R1", count_en[1], 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        k_edges = 0;
        #1;
        chk_bit("R1", count_en[0], 1'b0);
        for (int i = 0; i < 10; i++) cyc(3'd2, 3'd1, 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule